// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache between a processor and a memory port. It has 4096 lines. Each line holds a valid flag, a 16-bit tag and a four-word (128-bit) block. The processor issues 32-bit word reads and writes, and holds each request until the cache raises `cpu_ready`. A hit completes in the same cycle it is presented. The addressed word is picked out of the block by the word-offset bits of the address.

On a miss, read or write, the cache first waits until its write buffer is empty. It then requests the whole aligned block from memory and takes four data beats in word order, word 0 first, into the line. After that the held request completes as a hit.

Every write updates the cached word and also enters a four-entry write buffer. The buffer drains to memory one word per accepted handshake, in the order the writes were issued. A write stalls only while the buffer is full.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid. The first access to any index is a miss: `cpu_ready` stays low and a block fill is requested. While no request is presented, `cpu_ready`, `mem_rd_valid` and `mem_wr_valid` are low.
- R2: The byte address is split into four fields:
  - the tag in bits [31:16];
  - the line index in bits [15:4];
  - the word offset in bits [3:2];
  - bits [1:0], which are ignored for selection.
  Addresses with different index fields occupy different lines.
- R3: An access hits when the indexed line is valid and its stored tag equals the address tag. A read hit raises `cpu_ready` in the cycle it is presented, and `cpu_rdata` carries the word chosen by bits [3:2].
- R4: On a read miss, the cache drives `mem_rd_valid` with the block-aligned address (bits [3:0] zero) until `mem_rd_ready`. It then stores the four `mem_fill_valid` beats as words 0, 1, 2, 3 and sets the line's tag and valid flag. Only after that does it complete the access with the fetched word. `cpu_ready` is never high while a fill is pending.
- R5: A miss to an index whose line holds a different tag replaces that line. A later access with the old tag misses again.
- R6: A write hit completes in its first cycle and updates the cached word. A write miss first fills the whole block, then merges the written word. The other three words keep the memory values.
- R7: The write buffer holds up to 4 writes and presents them on `mem_wr_*` in issue order, removing one per cycle with `mem_wr_valid` and `mem_wr_ready` both high. A write presented while 4 writes are buffered stalls until an entry drains.
- R8: A block fill is not requested while any buffered write is still undrained.
- R9: `mem_rd_valid` with `mem_rd_addr`, and `mem_wr_valid` with `mem_wr_addr` and `mem_wr_data`, stay asserted and unchanged until their ready input is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` on reads |
| mem_rd_valid | output | 1 | Block fill request |
| mem_rd_addr | output | 32 | Block-aligned fill address |
| mem_rd_ready | input | 1 | Memory accepts the fill request |
| mem_fill_valid | input | 1 | Fill data beat present |
| mem_fill_data | input | 32 | Fill data word |
| mem_wr_valid | output | 1 | Buffered write present |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ready | input | 1 | Memory accepts the write |

## Verification
The assertions rest on these assumptions about the block's inputs:
- the processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from the cycle a request appears until the cycle `cpu_ready` is high;
- memory sends exactly four `mem_fill_valid` beats, and only after it has accepted a fill request.

The bench drives the processor side from one task that holds every request until completion. Its memory model sends beats only after granting `mem_rd_ready`, and it inserts a one-cycle gap inside each burst. Write-port back-pressure comes only from the model's `mem_wr_ready`, which the stimulus holds low for set stretches of cycles to fill the buffer and delay misses.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int INDEX_W  = 12,
  parameter int WOFF_W   = 2,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ready,
  input  logic        mem_fill_valid,
  input  logic [31:0] mem_fill_data,
  output logic        mem_wr_valid,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ready
);
  localparam int LINES  = 1 << INDEX_W;
  localparam int WORDS  = 1 << WOFF_W;
  localparam int LINE_W = 32 * WORDS;
  localparam int LO     = 2 + WOFF_W;
  localparam int TAG_W  = 32 - LO - INDEX_W;
  localparam int WB_AW  = $clog2(WB_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_REQ, S_FILL} state_t;

  state_t              st;
  logic [LINES-1:0]    valid_q;
  logic [TAG_W-1:0]    tag_q  [LINES];
  logic [LINE_W-1:0]   line_q [LINES];
  logic [31:0]         miss_addr;
  logic [WOFF_W-1:0]   beat;

  logic [31:0]         wb_a [WB_DEPTH];
  logic [31:0]         wb_d [WB_DEPTH];
  logic [WB_AW-1:0]    wb_wp, wb_rp;
  logic [WB_AW:0]      wb_cnt;

  wire [INDEX_W-1:0] idx   = cpu_addr[LO +: INDEX_W];
  wire [TAG_W-1:0]   tag   = cpu_addr[31 -: TAG_W];
  wire [WOFF_W-1:0]  woff  = cpu_addr[2 +: WOFF_W];
  wire [INDEX_W-1:0] m_idx = miss_addr[LO +: INDEX_W];
  wire               hit   = valid_q[idx] && (tag_q[idx] == tag);
  wire               wb_full = (wb_cnt == (WB_AW+1)'(WB_DEPTH));
  wire               push  = cpu_ready && cpu_we;
  wire               pop   = mem_wr_valid && mem_wr_ready;

  assign cpu_ready    = (st == S_IDLE) && cpu_req && hit && !(cpu_we && wb_full);
  assign cpu_rdata    = line_q[idx][woff*32 +: 32];
  assign mem_rd_valid = (st == S_REQ);
  assign mem_rd_addr  = {miss_addr[31:LO], {LO{1'b0}}};
  assign mem_wr_valid = (wb_cnt != '0);
  assign mem_wr_addr  = wb_a[wb_rp];
  assign mem_wr_data  = wb_d[wb_rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      valid_q   <= '0;
      miss_addr <= '0;
      beat      <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req && !hit) begin
          miss_addr <= cpu_addr;
          st        <= S_DRAIN;
        end
        S_DRAIN: if (wb_cnt == '0) st <= S_REQ;
        S_REQ: if (mem_rd_ready) begin
          valid_q[m_idx] <= 1'b0;
          beat           <= '0;
          st             <= S_FILL;
        end
        S_FILL: if (mem_fill_valid) begin
          beat <= beat + 1'b1;
          if (beat == WOFF_W'(WORDS-1)) begin
            valid_q[m_idx] <= 1'b1;
            st             <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_REQ && mem_rd_ready)
      tag_q[m_idx] <= miss_addr[31 -: TAG_W];
    if (st == S_FILL && mem_fill_valid)
      line_q[m_idx][beat*32 +: 32] <= mem_fill_data;
    else if (push)
      line_q[idx][woff*32 +: 32] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_wp  <= '0;
      wb_rp  <= '0;
      wb_cnt <= '0;
    end else begin
      if (push) begin
        wb_a[wb_wp] <= {cpu_addr[31:2], 2'b00};
        wb_d[wb_wp] <= cpu_wdata;
        wb_wp       <= wb_wp + 1'b1;
      end
      if (pop) wb_rp <= wb_rp + 1'b1;
      wb_cnt <= wb_cnt + (WB_AW+1)'(push) - (WB_AW+1)'(pop);
    end
  end
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_ready,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_ready,
  input logic        mem_wr_valid,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data,
  input logic        mem_wr_ready
);
  a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
  a_r4_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[3:0] == 4'h0));
  a_r4_no_done_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !cpu_ready);
  a_r8_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !mem_wr_valid);
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
endmodule

bind dm_wt_cache dm_wt_cache_chk u_chk (.*);

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ready, mem_rd_valid, mem_wr_valid;
  logic [31:0] cpu_rdata, mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic mem_rd_ready = 0, mem_fill_valid = 0, mem_wr_ready = 0;
  logic [31:0] mem_fill_data = 0;

  dm_wt_cache u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int issued = 0, drained = 0;
  bit wr_en = 1;
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];
  logic [31:0] rd_exp [$];
  logic [63:0] wr_exp [$];

  function automatic logic [31:0] init_val(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h0101};
  endfunction
  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : init_val(a);
  endfunction
  function automatic logic [31:0] ref_rd(logic [31:0] a);
    return ref_m.exists(a) ? ref_m[a] : init_val(a);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: holds a request until done, returns wait cycles
  task automatic access(bit we, logic [31:0] a, logic [31:0] d, output int waits);
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    @(negedge clk);
    if (we) begin
      ref_m[wa] = d;
      wr_exp.push_back({wa, d});
    end else rd_exp.push_back(ref_rd(wa));
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      waits++;
      if (waits > 500) break;
    end
    @(posedge clk);
    #1 cpu_req = 0;
  endtask

  // monitor: compares read results against the expected queue
  initial forever begin
    @(negedge clk); #2;
    if (rst_n) begin
      chk(!(mem_rd_valid && issued != drained), "R8", issued - drained, 0);
      if (cpu_req && cpu_ready) begin
        if (cpu_we) issued++;
        else if (rd_exp.size() != 0) begin
          logic [31:0] e;
          e = rd_exp.pop_front();
          chk(cpu_rdata === e, "R3", cpu_rdata, e);
        end
      end
    end
  end

  // memory model: fill port
  initial forever begin
    @(negedge clk);
    if (mem_rd_valid) begin
      logic [31:0] ba;
      ba = mem_rd_addr;
      chk(ba[3:0] == 0, "R4", ba, {ba[31:4], 4'h0});
      mem_rd_ready = 1;
      @(negedge clk);
      mem_rd_ready = 0;
      repeat (2) @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        mem_fill_valid = 1;
        mem_fill_data = mem_rd(ba + 32'(4*b));
        @(negedge clk);
        mem_fill_valid = 0;
        if (b == 1) @(negedge clk);
      end
    end
  end

  // memory model: write port with scoreboard on drained writes
  initial begin
    logic [31:0] held_a;
    bit held = 0;
    forever begin
      @(negedge clk);
      if (held && mem_wr_valid) chk(mem_wr_addr === held_a, "R9", mem_wr_addr, held_a);
      mem_wr_ready = wr_en;
      held = 0;
      if (mem_wr_valid && wr_en) begin
        logic [63:0] e;
        e = (wr_exp.size() != 0) ? wr_exp.pop_front() : 64'hx;
        chk({mem_wr_addr, mem_wr_data} === e, "R7", mem_wr_data, e[31:0]);
        mem_m[mem_wr_addr] = mem_wr_data;
        drained++;
      end else if (mem_wr_valid) begin
        held = 1; held_a = mem_wr_addr;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  localparam logic [31:0] A = 32'h0001_0120;
  localparam logic [31:0] B = 32'h0001_0130;
  localparam logic [31:0] C = 32'h0002_0120;
  localparam logic [31:0] D = 32'h0003_0208;

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!cpu_ready && !mem_rd_valid && !mem_wr_valid, "R1", {cpu_ready, mem_rd_valid, mem_wr_valid}, 0);

    access(0, A, 0, w);      chk(w > 4, "R1 first access misses", w, 5);
    for (int k = 1; k < 4; k++) begin
      access(0, A + 32'(4*k), 0, w); chk(w == 0, "R3 hit same cycle", w, 0);
    end
    access(0, A | 32'h3, 0, w); chk(w == 0, "R2 byte offset ignored", w, 0);
    access(0, B, 0, w);      chk(w > 4, "R2 new index misses", w, 5);
    access(0, A + 8, 0, w);  chk(w == 0, "R2 other index kept", w, 0);
    access(0, C, 0, w);      chk(w > 4, "R5 conflict misses", w, 5);
    access(0, A, 0, w);      chk(w > 4, "R5 old tag evicted", w, 5);

    access(1, A + 4, 32'hCAFE_0001, w); chk(w == 0, "R6 write hit", w, 0);
    access(0, A + 4, 0, w);  chk(w == 0, "R6 read after write hit", w, 0);
    access(1, D, 32'hBEEF_0002, w);     chk(w > 4, "R6 write miss fills", w, 5);
    access(0, D, 0, w);      chk(w == 0, "R6 merged word hit", w, 0);
    access(0, D + 4, 0, w);  chk(w == 0, "R6 neighbour word hit", w, 0);

    wr_en = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      access(1, A + 32'(4*k), 32'h1000_0000 + 32'(k), w);
      chk(w == 0, "R7 buffer room", w, 0);
    end
    fork begin repeat (6) @(negedge clk); wr_en = 1; end join_none
    access(1, A + 8, 32'h2222_0005, w); chk(w >= 5, "R7 full buffer stalls", w, 5);
    access(0, A + 8, 0, w);  chk(w == 0, "R7 stalled write landed", w, 0);

    wr_en = 0;
    repeat (3) @(negedge clk);
    access(1, B, 32'h3333_0006, w);
    fork begin repeat (8) @(negedge clk); wr_en = 1; end join_none
    access(0, C + 4, 0, w);  chk(w >= 12, "R8 miss waits for drain", w, 12);

    repeat (20) @(negedge clk);
    chk(wr_exp.size() == 0, "R7 all writes drained in order", wr_exp.size(), 0);
    chk(rd_exp.size() == 0, "R3 all reads answered", rd_exp.size(), 0);
    finish_run();
  end
endmodule